// File: doc/BRIEF.md
# Receive FIFO with Overrun Discard

This block buffers samples from a serial receiver on their way to a CPU. The receiver offers at most one sample per clock on a push strobe. The CPU drains the queue through a pop strobe, and the popped word appears on a registered read port one cycle later. The queue holds twelve entries in arrival order.

Two signals tell the CPU how the queue stands. The first is a service-request flag that rises once the queue is half full (six or more entries) and falls again at five or fewer. It drives an interrupt line only while the CPU's enable bit is set. The second is a sticky overrun status bit. When a sample arrives and every location is already occupied, that sample is thrown away and the stored contents are kept. Each such lost sample sets the status again. The overrun status drives an interrupt line that no enable bit can block. The CPU clears the status by writing a 1 on a clear strobe, but a sample lost in that same cycle keeps the bit set.

Top module: `rx_overrun_fifo`

## Requirements
- R1: While reset is high, and in the first cycle after it, the level is 0, the read word is 0, and all flags and interrupt lines are 0.
- R2: Samples leave in the order they arrived. A pop of a non-empty queue shows the oldest entry on the read port one clock after the pop strobe is sampled.
- R3: The service-request flag is 1 whenever the level is six or more.
- R4: The service-request flag is 0 whenever the level is five or fewer.
- R5: The service interrupt equals the service-request flag ANDed with the enable input. With the enable at 0, the interrupt stays 0 at any level.
- R6: A push sampled while the level is twelve is discarded. Stored contents and their order are kept, and the level does not rise. This holds even if a pop happens in the same cycle.
- R7: The overrun status becomes 1 one clock after each discarded push, and it stays 1 until it is cleared.
- R8: The overrun interrupt is 1 whenever the overrun status is 1, whatever the enable input is.
- R9: A clear strobe clears the overrun status one clock later. If a push is discarded in the same cycle as the clear, the status stays 1.
- R10: A pop of an empty queue puts 0 on the read port and leaves the level unchanged.
- R11: An accepted push and a pop of a non-empty queue in the same cycle leave the level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| push_valid | input | 1 | Receiver offers a sample this cycle |
| push_data | input | 16 | Sample from the receiver |
| pop_strobe | input | 1 | CPU read of the queue |
| pop_data | output | 16 | Registered read word (0 after a pop of an empty queue) |
| level | output | 4 | Number of stored entries |
| req_enable | input | 1 | Enable for the service interrupt |
| svc_req_flag | output | 1 | Half-full service request |
| svc_irq | output | 1 | Service interrupt, gated by the enable |
| ovr_clr_wr | input | 1 | CPU write of 1 to the overrun status (clears it) |
| ovr_status | output | 1 | Sticky overrun status |
| ovr_irq | output | 1 | Overrun interrupt, never masked |

## Verification
The pop word, the level, the service-request flag and the overrun status are all registers. Each one changes on the first rising edge that samples the stimulus that drives it. The two interrupt lines follow those registers within the same cycle; the service line also follows the enable input as soon as it changes. Inputs are therefore driven at a falling edge, held through the next rising edge, and every output is compared at the falling edge after that against a queue model that advances once per rising edge. The cases that matter are the edges of the level: the step between five and six entries, a push at twelve entries with and without a pop, a clear in the same cycle as a lost sample, and a pop of an empty queue.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int unsigned RXQ_DEPTH_DEF = 12;
    localparam int unsigned RXQ_WIDTH_DEF = 16;

    // Per-cycle decisions taken from the current level and the strobes
    typedef struct packed {
        logic store;   // push accepted into storage
        logic fetch;   // pop of a non-empty queue
        logic blank;   // pop of an empty queue: read word forced to zero
        logic drop;    // push arriving while full
    } rxq_evt_t;

    typedef enum logic [1:0] {
        OVR_KEEP  = 2'd0,
        OVR_SET   = 2'd1,
        OVR_CLEAR = 2'd2
    } rxq_ovr_act_t;

    // Circular pointer advance
    function automatic int unsigned rxq_step(input int unsigned ptr, input int unsigned depth);
        return (ptr + 1 == depth) ? 0 : ptr + 1;
    endfunction

endpackage

// File: rtl/rxq_storage.sv
module rxq_storage
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = RXQ_DEPTH_DEF,
    parameter int unsigned WIDTH = RXQ_WIDTH_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    input  logic             rd_blank,
    output logic [WIDTH-1:0] rd_data
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            rd_data <= '0;
        end else begin
            if (wr_en) begin
                wr_ptr <= PTR_W'(rxq_step(int'(wr_ptr), DEPTH));
            end
            if (rd_en) begin
                rd_data <= mem[rd_ptr];
                rd_ptr  <= PTR_W'(rxq_step(int'(rd_ptr), DEPTH));
            end else if (rd_blank) begin
                rd_data <= '0;
            end
        end
    end

endmodule

// File: rtl/rxq_level.sv
module rxq_level
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH  = RXQ_DEPTH_DEF,
    parameter int unsigned THRESH = RXQ_DEPTH_DEF / 2,
    parameter int unsigned LVL_W  = $clog2(RXQ_DEPTH_DEF + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             dec,
    output logic [LVL_W-1:0] level,
    output logic             svc_flag
);
    logic [LVL_W-1:0] lvl_next;

    always_comb begin
        unique case ({inc, dec})
            2'b10:   lvl_next = level + LVL_W'(1);
            2'b01:   lvl_next = level - LVL_W'(1);
            default: lvl_next = level;
        endcase
    end

    // Flag registered from the next level so it moves together with level
    always_ff @(posedge clk) begin
        if (rst) begin
            level    <= '0;
            svc_flag <= 1'b0;
        end else begin
            level    <= lvl_next;
            svc_flag <= (lvl_next >= LVL_W'(THRESH));
        end
    end

endmodule

// File: rtl/rxq_overrun.sv
module rxq_overrun
    import rxq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic drop,
    input  logic clr_wr,
    output logic ovr
);
    rxq_ovr_act_t act;

    // A lost sample outranks the clear in the same cycle
    always_comb begin
        if (drop) begin
            act = OVR_SET;
        end else if (clr_wr) begin
            act = OVR_CLEAR;
        end else begin
            act = OVR_KEEP;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ovr <= 1'b0;
        end else begin
            unique case (act)
                OVR_SET:   ovr <= 1'b1;
                OVR_CLEAR: ovr <= 1'b0;
                default:   ovr <= ovr;
            endcase
        end
    end

endmodule

// File: rtl/rx_overrun_fifo.sv
module rx_overrun_fifo
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = RXQ_DEPTH_DEF,
    parameter int unsigned WIDTH = RXQ_WIDTH_DEF
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push_valid,
    input  logic [WIDTH-1:0]           push_data,
    input  logic                       pop_strobe,
    output logic [WIDTH-1:0]           pop_data,
    output logic [$clog2(DEPTH+1)-1:0] level,
    input  logic                       req_enable,
    output logic                       svc_req_flag,
    output logic                       svc_irq,
    input  logic                       ovr_clr_wr,
    output logic                       ovr_status,
    output logic                       ovr_irq
);
    localparam int unsigned LVL_W  = $clog2(DEPTH + 1);
    localparam int unsigned THRESH = DEPTH / 2;

    rxq_evt_t evt;
    logic     is_full;
    logic     is_empty;

    assign is_full  = (level == LVL_W'(DEPTH));
    assign is_empty = (level == '0);

    always_comb begin
        evt.store = push_valid && !is_full;
        evt.drop  = push_valid &&  is_full;
        evt.fetch = pop_strobe && !is_empty;
        evt.blank = pop_strobe &&  is_empty;
    end

    rxq_storage #(
        .DEPTH (DEPTH),
        .WIDTH (WIDTH)
    ) store_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (evt.store),
        .wr_data  (push_data),
        .rd_en    (evt.fetch),
        .rd_blank (evt.blank),
        .rd_data  (pop_data)
    );

    rxq_level #(
        .DEPTH  (DEPTH),
        .THRESH (THRESH),
        .LVL_W  (LVL_W)
    ) level_i (
        .clk      (clk),
        .rst      (rst),
        .inc      (evt.store),
        .dec      (evt.fetch),
        .level    (level),
        .svc_flag (svc_req_flag)
    );

    rxq_overrun ovr_i (
        .clk    (clk),
        .rst    (rst),
        .drop   (evt.drop),
        .clr_wr (ovr_clr_wr),
        .ovr    (ovr_status)
    );

    assign svc_irq = svc_req_flag & req_enable;
    assign ovr_irq = ovr_status;

endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
    parameter int unsigned DEPTH = 12,
    parameter int unsigned WIDTH = 16
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       push_valid,
    input logic                       pop_strobe,
    input logic [WIDTH-1:0]           pop_data,
    input logic [$clog2(DEPTH+1)-1:0] level,
    input logic                       ovr_clr_wr,
    input logic                       ovr_status,
    input logic                       ovr_irq
);
    localparam int unsigned LVL_W = $clog2(DEPTH + 1);

    // R6
    level_cap_chk: assert property (@(posedge clk) disable iff (rst)
        level <= LVL_W'(DEPTH));

    // R6
    full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (level == LVL_W'(DEPTH) && push_valid && !pop_strobe) |=> (level == LVL_W'(DEPTH)));

    // R7
    ovr_set_chk: assert property (@(posedge clk) disable iff (rst)
        (push_valid && level == LVL_W'(DEPTH)) |=> ovr_status);

    // R9
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (ovr_status && !ovr_clr_wr) |=> ovr_status);

    // R10
    empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (level == '0 && pop_strobe && !push_valid) |=> (level == '0 && pop_data == '0));

    // R8
    ovr_irq_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr_status) |-> ovr_irq);

endmodule

bind rx_overrun_fifo rxq_checker #(
    .DEPTH (DEPTH),
    .WIDTH (WIDTH)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .push_valid (push_valid),
    .pop_strobe (pop_strobe),
    .pop_data   (pop_data),
    .level      (level),
    .ovr_clr_wr (ovr_clr_wr),
    .ovr_status (ovr_status),
    .ovr_irq    (ovr_irq)
);

// File: tb/rx_overrun_fifo_tb_top.sv
module rx_overrun_fifo_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 12;
    localparam int WIDTH      = 16;
    localparam int THR        = 6;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             push_valid = 1'b0;
    logic [WIDTH-1:0] push_data = '0;
    logic             pop_strobe = 1'b0;
    logic [WIDTH-1:0] pop_data;
    logic [3:0]       level;
    logic             req_enable = 1'b0;
    logic             svc_req_flag;
    logic             svc_irq;
    logic             ovr_clr_wr = 1'b0;
    logic             ovr_status;
    logic             ovr_irq;

    int n_checks = 0;
    int n_fail   = 0;

    logic [WIDTH-1:0] q[$];
    int               m_pd  = 0;
    bit               m_ovr = 0;
    logic [WIDTH-1:0] seq   = 16'h1000;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_overrun_fifo dut_i (
        .clk          (clk),
        .rst          (rst),
        .push_valid   (push_valid),
        .push_data    (push_data),
        .pop_strobe   (pop_strobe),
        .pop_data     (pop_data),
        .level        (level),
        .req_enable   (req_enable),
        .svc_req_flag (svc_req_flag),
        .svc_irq      (svc_irq),
        .ovr_clr_wr   (ovr_clr_wr),
        .ovr_status   (ovr_status),
        .ovr_irq      (ovr_irq)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    task automatic compare_all();
        chk(pop_data == m_pd, "R2 R10 pop_data", int'(pop_data), m_pd);
        chk(level == q.size(), "R6 R10 R11 level", int'(level), q.size());
        chk(svc_req_flag == (q.size() >= THR), "R3 R4 svc_req_flag",
            int'(svc_req_flag), int'(q.size() >= THR));
        chk(svc_irq == ((q.size() >= THR) && req_enable), "R5 svc_irq",
            int'(svc_irq), int'((q.size() >= THR) && req_enable));
        chk(ovr_status == m_ovr, "R7 R9 ovr_status", int'(ovr_status), int'(m_ovr));
        chk(ovr_irq == m_ovr, "R8 ovr_irq", int'(ovr_irq), int'(m_ovr));
    endtask

    // Called at a falling edge: drive, let one rising edge pass, advance model, compare
    task automatic cycle(input bit p, input bit r, input bit c);
        bit full;
        bit empty;
        push_valid = p;
        push_data  = seq;
        pop_strobe = r;
        ovr_clr_wr = c;
        @(posedge clk);
        full  = (q.size() == DEPTH);
        empty = (q.size() == 0);
        if (r) m_pd = empty ? 0 : int'(q.pop_front());
        if (p && !full) q.push_back(push_data);
        if (p && full) m_ovr = 1;
        else if (c) m_ovr = 0;
        if (p) seq = seq + 16'h0101;
        @(negedge clk);
        push_valid = 1'b0;
        pop_strobe = 1'b0;
        ovr_clr_wr = 1'b0;
        compare_all();
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 4000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(level == 0 && pop_data == 0, "R1 reset level/data", int'(level), 0);
        chk(!svc_req_flag && !svc_irq && !ovr_status && !ovr_irq, "R1 reset flags",
            int'({svc_req_flag, svc_irq, ovr_status, ovr_irq}), 0);
        rst = 1'b0;
        req_enable = 1'b1;
        @(negedge clk);
        chk(level == 0 && pop_data == 0 && !ovr_status, "R1 after reset", int'(level), 0);

        // R2: ordering with a short burst
        for (int i = 0; i < 3; i++) cycle(1, 0, 0);
        for (int i = 0; i < 3; i++) cycle(0, 1, 0);
        // R10: pop of empty queue, twice, then push and pop together on empty
        cycle(0, 1, 0);
        cycle(0, 1, 0);
        cycle(1, 1, 0);
        cycle(0, 1, 0);

        // R3 R4: walk across the threshold
        for (int i = 0; i < 5; i++) cycle(1, 0, 0);
        cycle(1, 0, 0);
        cycle(0, 1, 0);
        cycle(1, 0, 0);
        // R5: enable off hides the service interrupt
        req_enable = 1'b0;
        cycle(0, 0, 0);
        cycle(1, 0, 0);
        req_enable = 1'b1;
        cycle(0, 0, 0);
        // R11: push and pop together mid-level
        cycle(1, 1, 0);
        cycle(1, 1, 0);

        // R6 R7: fill, then lose samples
        while (q.size() < DEPTH) cycle(1, 0, 0);
        for (int i = 0; i < 3; i++) cycle(1, 0, 0);
        cycle(0, 0, 0);
        // R8: overrun interrupt ignores the enable
        req_enable = 1'b0;
        cycle(0, 0, 0);
        req_enable = 1'b1;
        // R9: plain clear, then clear colliding with a lost sample
        cycle(0, 0, 1);
        cycle(0, 0, 0);
        cycle(1, 0, 1);
        cycle(0, 0, 1);
        // R6: push and pop together while full: push lost, pop proceeds
        cycle(1, 1, 0);
        cycle(0, 0, 1);
        cycle(1, 0, 0);

        // R2 R4: drain in order, then pop empty
        while (q.size() > 0) cycle(0, 1, 0);
        cycle(0, 1, 0);
        cycle(0, 0, 0);

        finish_run();
    end

endmodule